// File: doc/BRIEF.md
# Bridge-Aware PWM Ramp Modulator

This block produces pulse-width-modulated outputs from a digital ramp counter that advances once per tick strobe. The tick strobe normally arrives at 50 MHz, so one count is 20 ns. Each of the parallel channels has its own period, span mode, edge-placement mode, two edge commands and half-cycle select. In full-span mode the ramp runs from 0 to the period value and then wraps. In half-span mode, intended for bridge topologies, it wraps at half the period and labels each ramp cycle as the even or the odd half of the switching period.

Two edge markers are derived from the commands and the ramp span. The rise marker sets where the pulse goes high and the fall marker sets where it goes low. In trailing-edge mode the rise is pinned to count 0. In leading-edge mode the fall is pinned to the top of the ramp. In dual-edge mode both edges follow their commands. In half-span mode a pulse appears only in the half-cycle chosen by the select input. New settings take effect only when the ramp wraps, so a cycle already in progress is never cut short.

Top module: `pwm_ramp_mod`

## Requirements
- R1: While a channel is enabled, its ramp count rises by exactly one on every clock where `tick_i` is high and the count is below the span. On a clock without a tick the count holds.
- R2: The span is the latched period in full-span mode and the latched period shifted right by one (rounded down) in half-span mode. On a tick with the count equal to the span, the count returns to 0. The count never exceeds the span.
- R3: In half-span mode the phase flag `odd_half_o` inverts at every wrap (0 = even half, 1 = odd half). In full-span mode a wrap sets the flag to 0.
- R4: While a channel's enable is low, its count and phase flag are cleared to 0 on the next clock, its PWM output is low, and its latched settings follow the inputs on every clock.
- R5: Period, span mode, edge mode, both edge commands and half-cycle select are latched only at a wrap or while the channel is disabled. Changes made at any other time have no effect until the next wrap.
- R6: Edge mode 0 (trailing edge): the rise marker is 0 and the fall marker is the fall command. The output is high for counts 0 up to, but not including, the fall command.
- R7: Edge mode 1 (leading edge): the rise marker is the rise command and the fall marker is the span. The output is high for counts from the rise command up to, but not including, the span.
- R8: Edge modes 2 and 3 (dual edge): the rise marker is the rise command and the fall marker is the fall command. The output is high for counts from the rise command up to, but not including, the fall command.
- R9: If the rise marker is not below the fall marker, or the fall marker is above the span, the output stays low for the whole ramp cycle.
- R10: In half-span mode the output can be high only while the phase flag equals the latched half-cycle select (0 = even, 1 = odd). In full-span mode the select has no effect.
- R11: Channels are independent. Settings, enable and state of one channel never change another channel's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Ramp advance strobe, shared by all channels |
| enable_i | input | NUM_RAMPS | Per-channel run enable |
| period_i | input | NUM_RAMPS x CNT_W | Switching period in ticks |
| half_mode_i | input | NUM_RAMPS | 1 = half-span (bridge) mode |
| mod_sel_i | input | NUM_RAMPS x 2 | Edge mode: 0 trailing, 1 leading, 2/3 dual |
| duty_rise_i | input | NUM_RAMPS x CNT_W | Rise edge command |
| duty_fall_i | input | NUM_RAMPS x CNT_W | Fall edge command |
| half_sel_i | input | NUM_RAMPS | Active half-cycle in half-span mode (0 even, 1 odd) |
| pwm_o | output | NUM_RAMPS | PWM level |
| odd_half_o | output | NUM_RAMPS | Phase flag, 1 = odd half |
| ramp_cnt_o | output | NUM_RAMPS x CNT_W | Current ramp count |

## Verification
The hardest situation to reach is a setting change that lands in the middle of a ramp cycle while the channel is in half-span mode. A correct design must keep the old span, edges and half select until the wrap, and it must also keep the phase parity right across a disable that clears it back to even. The stimulus reaches this by rewriting settings at random clocks that are unrelated to the tick phase. It also toggles enables in the middle of a cycle and mixes odd periods with both half selects. A behavioural model in the bench follows the latch-at-wrap rule and is compared with the outputs after every clock.

// File: rtl/pwm_ramp_pkg.sv
package pwm_ramp_pkg;

  typedef enum logic [1:0] {
    MOD_TRAIL    = 2'd0,
    MOD_LEAD     = 2'd1,
    MOD_DUAL     = 2'd2,
    MOD_DUAL_ALT = 2'd3
  } mod_sel_e;

  // Gate for half-span mode: only the selected half may carry a pulse.
  function automatic logic phase_match(input logic half, input logic odd, input logic sel);
    return !half || (odd == sel);
  endfunction

endpackage

// File: rtl/pwm_ramp_counter.sv
module pwm_ramp_counter
  import pwm_ramp_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             half_i,
  input  mod_sel_e         mode_i,
  input  logic [CNT_W-1:0] rise_i,
  input  logic [CNT_W-1:0] fall_i,
  input  logic             sel_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             odd_o,
  output logic [CNT_W-1:0] span_o,
  output logic             wrap_o,
  output logic             half_o,
  output mod_sel_e         mode_o,
  output logic [CNT_W-1:0] rise_o,
  output logic [CNT_W-1:0] fall_o,
  output logic             sel_o
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  function automatic logic [CNT_W-1:0] span_of(input logic [CNT_W-1:0] per, input logic half);
    return half ? (per >> 1) : per;
  endfunction

  logic [CNT_W-1:0] cnt_q, per_q, rise_q, fall_q;
  logic             odd_q, half_q, sel_q;
  mod_sel_e         mode_q;
  logic             wrap_w, load_w;

  assign span_o = span_of(per_q, half_q);
  assign wrap_w = en_i && tick_i && (cnt_q == span_o);
  assign load_w = !en_i || wrap_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      odd_q  <= 1'b0;
      per_q  <= '0;
      half_q <= 1'b0;
      mode_q <= MOD_TRAIL;
      rise_q <= '0;
      fall_q <= '0;
      sel_q  <= 1'b0;
    end else begin
      if (!en_i) begin
        cnt_q <= '0;
        odd_q <= 1'b0;
      end else if (wrap_w) begin
        cnt_q <= '0;
        odd_q <= half_q ? ~odd_q : 1'b0;
      end else if (tick_i) begin
        cnt_q <= cnt_q + ONE;
      end
      if (load_w) begin
        per_q  <= period_i;
        half_q <= half_i;
        mode_q <= mode_i;
        rise_q <= rise_i;
        fall_q <= fall_i;
        sel_q  <= sel_i;
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign odd_o  = odd_q;
  assign wrap_o = wrap_w;
  assign half_o = half_q;
  assign mode_o = mode_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;
  assign sel_o  = sel_q;

endmodule

// File: rtl/pwm_edge_place.sv
module pwm_edge_place
  import pwm_ramp_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  mod_sel_e         mode_i,
  input  logic [CNT_W-1:0] rise_i,
  input  logic [CNT_W-1:0] fall_i,
  input  logic [CNT_W-1:0] span_i,
  output logic [CNT_W-1:0] t1_o,
  output logic [CNT_W-1:0] t2_o,
  output logic             valid_o
);

  always_comb begin
    unique case (mode_i)
      MOD_TRAIL: begin
        t1_o = '0;
        t2_o = fall_i;
      end
      MOD_LEAD: begin
        t1_o = rise_i;
        t2_o = span_i;
      end
      default: begin
        t1_o = rise_i;
        t2_o = fall_i;
      end
    endcase
  end

  assign valid_o = (t1_o < t2_o) && (t2_o <= span_i);

endmodule

// File: rtl/pwm_pulse_form.sv
module pwm_pulse_form
  import pwm_ramp_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] t1_i,
  input  logic [CNT_W-1:0] t2_i,
  input  logic             valid_i,
  input  logic             half_i,
  input  logic             odd_i,
  input  logic             sel_i,
  output logic             pwm_o
);

  logic in_window;

  assign in_window = (cnt_i >= t1_i) && (cnt_i < t2_i);
  assign pwm_o     = en_i && valid_i && in_window && phase_match(half_i, odd_i, sel_i);

endmodule

// File: rtl/pwm_ramp_mod.sv
module pwm_ramp_mod
  import pwm_ramp_pkg::*;
#(
  parameter int NUM_RAMPS = 2,
  parameter int CNT_W     = 9
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            tick_i,
  input  logic [NUM_RAMPS-1:0]            enable_i,
  input  logic [NUM_RAMPS-1:0][CNT_W-1:0] period_i,
  input  logic [NUM_RAMPS-1:0]            half_mode_i,
  input  logic [NUM_RAMPS-1:0][1:0]       mod_sel_i,
  input  logic [NUM_RAMPS-1:0][CNT_W-1:0] duty_rise_i,
  input  logic [NUM_RAMPS-1:0][CNT_W-1:0] duty_fall_i,
  input  logic [NUM_RAMPS-1:0]            half_sel_i,
  output logic [NUM_RAMPS-1:0]            pwm_o,
  output logic [NUM_RAMPS-1:0]            odd_half_o,
  output logic [NUM_RAMPS-1:0][CNT_W-1:0] ramp_cnt_o
);

  // Internal events brought out for the bound checker.
  logic [NUM_RAMPS-1:0]            wrap_w;
  logic [NUM_RAMPS-1:0][CNT_W-1:0] span_w;
  logic [NUM_RAMPS-1:0]            half_w;
  logic [NUM_RAMPS-1:0]            sel_w;

  for (genvar g = 0; g < NUM_RAMPS; g++) begin : g_ramp
    mod_sel_e         mode_q;
    logic [CNT_W-1:0] rise_q, fall_q, t1, t2;
    logic             valid;

    pwm_ramp_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (enable_i[g]),
      .tick_i   (tick_i),
      .period_i (period_i[g]),
      .half_i   (half_mode_i[g]),
      .mode_i   (mod_sel_e'(mod_sel_i[g])),
      .rise_i   (duty_rise_i[g]),
      .fall_i   (duty_fall_i[g]),
      .sel_i    (half_sel_i[g]),
      .cnt_o    (ramp_cnt_o[g]),
      .odd_o    (odd_half_o[g]),
      .span_o   (span_w[g]),
      .wrap_o   (wrap_w[g]),
      .half_o   (half_w[g]),
      .mode_o   (mode_q),
      .rise_o   (rise_q),
      .fall_o   (fall_q),
      .sel_o    (sel_w[g])
    );

    pwm_edge_place #(.CNT_W(CNT_W)) u_edge (
      .mode_i  (mode_q),
      .rise_i  (rise_q),
      .fall_i  (fall_q),
      .span_i  (span_w[g]),
      .t1_o    (t1),
      .t2_o    (t2),
      .valid_o (valid)
    );

    pwm_pulse_form #(.CNT_W(CNT_W)) u_pulse (
      .en_i    (enable_i[g]),
      .cnt_i   (ramp_cnt_o[g]),
      .t1_i    (t1),
      .t2_i    (t2),
      .valid_i (valid),
      .half_i  (half_w[g]),
      .odd_i   (odd_half_o[g]),
      .sel_i   (sel_w[g]),
      .pwm_o   (pwm_o[g])
    );
  end

endmodule

// File: rtl/pwm_ramp_mod_chk.sv
module pwm_ramp_mod_chk #(
  parameter int NUM_RAMPS = 2,
  parameter int CNT_W     = 9
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            tick_i,
  input logic [NUM_RAMPS-1:0]            enable_i,
  input logic [NUM_RAMPS-1:0]            pwm_o,
  input logic [NUM_RAMPS-1:0]            odd_half_o,
  input logic [NUM_RAMPS-1:0][CNT_W-1:0] ramp_cnt_o,
  input logic [NUM_RAMPS-1:0]            wrap_w,
  input logic [NUM_RAMPS-1:0][CNT_W-1:0] span_w,
  input logic [NUM_RAMPS-1:0]            half_w,
  input logic [NUM_RAMPS-1:0]            sel_w
);

  for (genvar g = 0; g < NUM_RAMPS; g++) begin : g_chk
    // R1
    cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (enable_i[g] && tick_i && !wrap_w[g]) |=> (ramp_cnt_o[g] == $past(ramp_cnt_o[g]) + 1'b1));
    // R1
    cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (enable_i[g] && !tick_i) |=> $stable(ramp_cnt_o[g]));
    // R2
    span_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ramp_cnt_o[g] <= span_w[g]);
    // R2
    wrap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wrap_w[g] |=> (ramp_cnt_o[g] == '0));
    // R3
    odd_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wrap_w[g] && half_w[g]) |=> (odd_half_o[g] != $past(odd_half_o[g])));
    // R3
    odd_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wrap_w[g] && !half_w[g]) |=> !odd_half_o[g]);
    // R4
    disabled_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !enable_i[g] |=> (ramp_cnt_o[g] == '0 && !odd_half_o[g]));
    // R4
    disabled_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !enable_i[g] |-> !pwm_o[g]);
    // R10
    half_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pwm_o[g] && half_w[g]) |-> (odd_half_o[g] == sel_w[g]));
  end

endmodule

bind pwm_ramp_mod pwm_ramp_mod_chk #(.NUM_RAMPS(NUM_RAMPS), .CNT_W(CNT_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .enable_i   (enable_i),
  .pwm_o      (pwm_o),
  .odd_half_o (odd_half_o),
  .ramp_cnt_o (ramp_cnt_o),
  .wrap_w     (wrap_w),
  .span_w     (span_w),
  .half_w     (half_w),
  .sel_w      (sel_w)
);

// File: tb/pwm_ramp_mod_tb_top.sv
`timescale 1ns/1ps
module pwm_ramp_mod_tb_top;

  localparam int N = 2;
  localparam int W = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [N-1:0]        en = '0;
  logic [N-1:0][W-1:0] per = '0;
  logic [N-1:0]        half = '0;
  logic [N-1:0][1:0]   mode = '0;
  logic [N-1:0][W-1:0] rise = '0;
  logic [N-1:0][W-1:0] fall = '0;
  logic [N-1:0]        hsel = '0;
  logic [N-1:0]        pwm;
  logic [N-1:0]        odd;
  logic [N-1:0][W-1:0] cnt;

  always #2 clk = ~clk; // 250 MHz

  pwm_ramp_mod #(.NUM_RAMPS(N), .CNT_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .enable_i(en),
    .period_i(per), .half_mode_i(half), .mod_sel_i(mode),
    .duty_rise_i(rise), .duty_fall_i(fall), .half_sel_i(hsel),
    .pwm_o(pwm), .odd_half_o(odd), .ramp_cnt_o(cnt)
  );

  int checks = 0;
  int fails = 0;
  string cur_req = "R4";
  bit checking = 1'b0;
  int tick_div = 5;
  int tick_phase = 0;

  // Behavioural reference state
  int m_cnt[N], m_odd[N];
  int s_per[N], s_half[N], s_mode[N], s_rise[N], s_fall[N], s_sel[N];

  function automatic int span_ref(int c);
    return s_half[c] != 0 ? s_per[c] / 2 : s_per[c];
  endfunction

  function automatic int pwm_ref(int c);
    int a, b, sp;
    sp = span_ref(c);
    if (s_mode[c] == 0) begin a = 0; b = s_fall[c]; end
    else if (s_mode[c] == 1) begin a = s_rise[c]; b = sp; end
    else begin a = s_rise[c]; b = s_fall[c]; end
    if (!en[c]) return 0;
    if (a >= b || b > sp) return 0;
    if (s_half[c] != 0 && m_odd[c] != s_sel[c]) return 0;
    return (m_cnt[c] >= a && m_cnt[c] < b) ? 1 : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    for (int c = 0; c < N; c++) begin
      if (!rst_n) begin
        m_cnt[c] = 0; m_odd[c] = 0;
        s_per[c] = 0; s_half[c] = 0; s_mode[c] = 0; s_rise[c] = 0; s_fall[c] = 0; s_sel[c] = 0;
      end else begin
        bit load;
        load = 1'b0;
        if (!en[c]) begin
          m_cnt[c] = 0; m_odd[c] = 0; load = 1'b1;
        end else if (tick) begin
          if (m_cnt[c] == span_ref(c)) begin
            m_cnt[c] = 0;
            m_odd[c] = (s_half[c] != 0) ? 1 - m_odd[c] : 0;
            load = 1'b1;
          end else begin
            m_cnt[c] = m_cnt[c] + 1;
          end
        end
        if (load) begin
          s_per[c] = int'(per[c]); s_half[c] = int'(half[c]); s_mode[c] = int'(mode[c]);
          s_rise[c] = int'(rise[c]); s_fall[c] = int'(fall[c]); s_sel[c] = int'(hsel[c]);
        end
      end
    end
  end

  task automatic cmp(string what, int c, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s ch%0d %s actual=%0d expected=%0d at %0t", cur_req, c, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && checking) begin
      for (int c = 0; c < N; c++) begin
        cmp("count", c, int'(cnt[c]), m_cnt[c]);
        cmp("phase", c, int'(odd[c]), m_odd[c]);
        cmp("pwm", c, int'(pwm[c]), pwm_ref(c));
      end
    end
  end

  // Tick strobe: every tick_div clocks (1 = every clock)
  always @(negedge clk) begin
    if (tick_div <= 1) tick <= 1'b1;
    else begin
      tick <= (tick_phase == 0);
      tick_phase <= (tick_phase + 1) % tick_div;
    end
  end

  task automatic cfg(int c, int p, int h, int md, int r, int f, int s);
    per[c] = W'(p); half[c] = h[0]; mode[c] = md[1:0];
    rise[c] = W'(r); fall[c] = W'(f); hsel[c] = s[0];
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    run(3);
    @(negedge clk) rst_n = 1'b1;
    checking = 1'b1;
    // R4: reset state and disabled behaviour
    cur_req = "R4";
    for (int c = 0; c < N; c++) begin
      checks++;
      if (cnt[c] != 0 || odd[c] != 0 || pwm[c] != 0) begin
        fails++;
        $display("FAIL R4 ch%0d reset state actual=%0d/%0d/%0d expected=0/0/0", c, cnt[c], odd[c], pwm[c]);
      end
    end
    cfg(0, 10, 0, 0, 0, 4, 0);
    cfg(1, 7, 1, 0, 0, 2, 0);
    run(20);

    // R1: basic advance with a 1-in-5 tick
    cur_req = "R1";
    en = 2'b11;
    run(300);

    // R6: trailing edge, several commands
    cur_req = "R6";
    tick_div = 1;
    cfg(0, 12, 0, 0, 7, 5, 0);
    cfg(1, 20, 0, 0, 0, 20, 1);
    run(100);
    cfg(0, 12, 0, 0, 0, 1, 0);
    run(60);

    // R7: leading edge
    cur_req = "R7";
    cfg(0, 15, 0, 1, 3, 0, 0);
    cfg(1, 9, 0, 1, 8, 0, 0);
    run(100);

    // R8: dual edge, modes 2 and 3
    cur_req = "R8";
    cfg(0, 16, 0, 2, 4, 11, 0);
    cfg(1, 16, 0, 3, 0, 16, 0);
    run(100);

    // R9: invalid markers
    cur_req = "R9";
    cfg(0, 16, 0, 2, 9, 9, 0);
    cfg(1, 16, 0, 0, 0, 17, 0);
    run(80);
    cfg(0, 16, 0, 2, 12, 3, 0);
    cfg(1, 11, 1, 1, 6, 0, 0);
    run(80);

    // R3: half-span parity with odd period
    cur_req = "R3";
    cfg(0, 9, 1, 0, 0, 3, 0);
    cfg(1, 9, 0, 0, 0, 3, 1);
    run(200);

    // R10: half select both ways, full mode ignores it
    cur_req = "R10";
    cfg(0, 14, 1, 2, 1, 5, 1);
    cfg(1, 14, 0, 2, 1, 5, 1);
    run(150);
    cfg(0, 14, 1, 2, 1, 5, 0);
    run(150);

    // R2: span extremes
    cur_req = "R2";
    cfg(0, 0, 0, 0, 0, 0, 0);
    cfg(1, 1, 1, 0, 0, 1, 0);
    run(60);
    cfg(0, 511, 0, 2, 100, 400, 0);
    cfg(1, 511, 1, 1, 50, 0, 1);
    run(1300);

    // R5: settings rewritten mid-cycle at arbitrary clocks
    cur_req = "R5";
    tick_div = 3;
    for (int i = 0; i < 120; i++) begin
      int c;
      c = $urandom_range(0, 1);
      cfg(c, $urandom_range(0, 30), $urandom_range(0, 1), $urandom_range(0, 3),
          $urandom_range(0, 20), $urandom_range(0, 25), $urandom_range(0, 1));
      run($urandom_range(1, 17));
    end

    // R4: enable toggles mid-cycle, parity back to even
    cur_req = "R4";
    tick_div = 1;
    cfg(0, 13, 1, 2, 2, 6, 1);
    cfg(1, 13, 1, 2, 2, 6, 0);
    for (int i = 0; i < 40; i++) begin
      en[$urandom_range(0, 1)] = 1'($urandom_range(0, 1));
      run($urandom_range(1, 25));
    end
    en = 2'b11;

    // R11: one channel disabled while the other runs, random settings
    cur_req = "R11";
    en = 2'b01;
    cfg(1, 5, 0, 0, 0, 3, 0);
    for (int i = 0; i < 200; i++) begin
      cfg(0, $urandom_range(0, 40), $urandom_range(0, 1), $urandom_range(0, 3),
          $urandom_range(0, 25), $urandom_range(0, 30), $urandom_range(0, 1));
      if (i == 100) en = 2'b10;
      tick_div = (i % 2 == 0) ? 1 : 4;
      run($urandom_range(2, 30));
    end

    checking = 1'b0;
    run(2);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule